// File: doc/BRIEF.md
# Single-RAM Hardware Stack

This block is the operand stack of a small stack-machine processor. All stored elements sit in one synchronous RAM. The RAM is written in write-first fashion, so the value at the top of the stack is always the RAM's registered output, with no separate top register. The address is formed combinationally from the pointer value that will hold after the current edge. Each command therefore finishes on one clock edge, and the new top is visible right after that edge.

Each cycle the block takes at most one command: push a value, pop the top, or overwrite the top in place. The block reports the stored depth, empty and full, and a sticky error flag. The error flag records any command that could not be carried out.

Top module: `hw_stack`

## Requirements
- R1: After reset the depth is 0. `empty_o` is 1, `full_o` is 0, `err_o` is 0, `top_valid_o` is 0 and `top_o` is 0.
- R2: A push when not full stores `wdata_i` as the new top and raises the depth by one. Both are visible right after that clock edge.
- R3: A pop when not empty lowers the depth by one. Right after that edge, `top_o` shows the element below the old top, in last-in-first-out order.
- R4: A replace-top when not empty overwrites the top with `wdata_i` and leaves the depth unchanged. The new value is visible right after the edge.
- R5: When more than one command is asserted in the same cycle, only one is acted on: push over pop, and pop over replace-top.
- R6: A push while full leaves the depth and the top unchanged and sets `err_o`.
- R7: A pop or a replace-top while empty leaves the depth at 0 and sets `err_o`.
- R8: Once set, `err_o` stays at 1 until reset.
- R9: `empty_o` is 1 exactly when the depth is 0, and `full_o` is 1 exactly when the depth equals DEPTH. While the stack is empty, `top_valid_o` is 0 and `top_o` is 0.
- R10: In a cycle with no command, the depth and `top_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push `wdata_i` |
| pop_i | input | 1 | Remove the top element |
| repl_i | input | 1 | Overwrite the top element with `wdata_i` |
| wdata_i | input | DATA_W | Data for push or replace-top |
| top_o | output | DATA_W | Current top element, 0 when empty |
| top_valid_o | output | 1 | A top element exists |
| empty_o | output | 1 | Depth is 0 |
| full_o | output | 1 | Depth equals DEPTH |
| depth_o | output | $clog2(DEPTH+1) | Number of stored elements |
| err_o | output | 1 | Sticky flag for a refused command |

## Verification
The pointer fixes the RAM address, so a wrong pointer shows up on `top_o` on the first edge after the bad update. It can appear as a stale or misplaced value after a pop, or as a replace that lands on the wrong element. A wrong depth shows on `depth_o`, `empty_o` and `full_o` in the same cycle it is registered. A missed boundary check shows as a depth that wraps, or as an error flag that is missing one edge after the refused command. The tests walk the stack down to empty and up to full, and pop the whole contents back out, so that an address error anywhere in the RAM reaches the ports.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_REPL = 2'd3
    } stk_op_e;

    // Priority: push, then pop, then replace-top.
    function automatic stk_op_e pick_op(input logic push, input logic pop, input logic repl);
        if (push)      return OP_PUSH;
        else if (pop)  return OP_POP;
        else if (repl) return OP_REPL;
        else           return OP_IDLE;
    endfunction

endpackage

// File: rtl/stk_arbiter.sv
module stk_arbiter
    import stk_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    repl_i,
    input  logic    empty_i,
    input  logic    full_i,
    output stk_op_e op_o,
    output logic    refuse_o
);
    stk_op_e want;

    always_comb begin
        want     = pick_op(push_i, pop_i, repl_i);
        op_o     = want;
        refuse_o = 1'b0;
        unique case (want)
            OP_PUSH: if (full_i)  begin op_o = OP_IDLE; refuse_o = 1'b1; end
            OP_POP,
            OP_REPL: if (empty_i) begin op_o = OP_IDLE; refuse_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_op_e       op_i,
    input  logic          refuse_i,
    output logic [CW-1:0] depth_o,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic          err_o
);
    logic [CW-1:0] depth_q, depth_nx;
    logic          err_q;

    always_comb begin
        depth_nx = depth_q;
        unique case (op_i)
            OP_PUSH: depth_nx = depth_q + CW'(1);
            OP_POP:  depth_nx = depth_q - CW'(1);
            default: ;
        endcase
    end

    // Address points at the top element as it will be after this edge.
    always_comb begin
        if (depth_nx == '0) addr_o = '0;
        else                addr_o = AW'(depth_nx - CW'(1));
    end

    assign we_o = (op_i == OP_PUSH) || (op_i == OP_REPL);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            err_q   <= 1'b0;
        end else begin
            depth_q <= depth_nx;
            if (refuse_i) err_q <= 1'b1;
        end
    end

    assign depth_o = depth_q;
    assign err_o   = err_q;
endmodule

// File: rtl/stk_wf_ram.sv
module stk_wf_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write-first: a written word also appears on the output at once.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= din;
            dout      <= din;
        end else begin
            dout      <= mem[addr];
        end
    end
endmodule

// File: rtl/hw_stack.sv
module hw_stack
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              repl_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] top_o,
    output logic              top_valid_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CW-1:0]     depth_o,
    output logic              err_o
);
    stk_op_e           op;
    logic              refuse;
    logic [CW-1:0]     depth;
    logic [AW-1:0]     addr;
    logic              we;
    logic [DATA_W-1:0] ram_q;

    assign empty_o = (depth == '0);
    assign full_o  = (depth == CW'(DEPTH));

    stk_arbiter u_arb (
        .push_i  (push_i),
        .pop_i   (pop_i),
        .repl_i  (repl_i),
        .empty_i (empty_o),
        .full_i  (full_o),
        .op_o    (op),
        .refuse_o(refuse)
    );

    stk_ptr_unit #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .refuse_i(refuse),
        .depth_o (depth),
        .addr_o  (addr),
        .we_o    (we),
        .err_o   (err_o)
    );

    stk_wf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk (clk),
        .we  (we),
        .addr(addr),
        .din (wdata_i),
        .dout(ram_q)
    );

    assign depth_o     = depth;
    assign top_valid_o = !empty_o;
    assign top_o       = top_valid_o ? ram_q : '0;
endmodule

// File: rtl/hw_stack_chk.sv
module hw_stack_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic              pop_i,
    input logic              repl_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] top_o,
    input logic              empty_o,
    input logic              full_o,
    input logic [CW-1:0]     depth_o,
    input logic              err_o
);
    assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> (top_o == $past(wdata_i)) && (depth_o == $past(depth_o) + 1'b1));

    assert_pop_depth_R3: assert property (@(posedge clk) disable iff (rst)
        (!push_i && pop_i && !empty_o) |=> (depth_o == $past(depth_o) - 1'b1));

    assert_repl_top_R4: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i && repl_i && !empty_o) |=> (top_o == $past(wdata_i)) && $stable(depth_o));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> err_o && $stable(depth_o) && $stable(top_o));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        ((pop_i || repl_i) && !push_i && empty_o) |=> err_o && (depth_o == '0));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    assert_flags_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({empty_o, full_o}) && (depth_o <= CW'(DEPTH)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i && !repl_i) |=> $stable(top_o) && $stable(depth_o));
endmodule

bind hw_stack hw_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .push_i (push_i),
    .pop_i  (pop_i),
    .repl_i (repl_i),
    .wdata_i(wdata_i),
    .top_o  (top_o),
    .empty_o(empty_o),
    .full_o (full_o),
    .depth_o(depth_o),
    .err_o  (err_o)
);

// File: tb/hw_stack_test.sv
module hw_stack_test;
    localparam int DW = 16;
    localparam int DP = 4;
    localparam int CW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          push_i, pop_i, repl_i;
    logic [DW-1:0] wdata_i;
    logic [DW-1:0] top_o;
    logic          top_valid_o, empty_o, full_o, err_o;
    logic [CW-1:0] depth_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    hw_stack #(.DATA_W(DW), .DEPTH(DP)) uut (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .repl_i(repl_i),
        .wdata_i(wdata_i), .top_o(top_o), .top_valid_o(top_valid_o),
        .empty_o(empty_o), .full_o(full_o), .depth_o(depth_o), .err_o(err_o)
    );

    typedef struct packed {
        logic          push;
        logic          pop;
        logic          repl;
        logic [DW-1:0] data;
        logic          valid;
        logic [DW-1:0] top;
        logic [2:0]    depth;
        logic          err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 16'h00A1, 1'b1, 16'h00A1, 3'd1, 1'b0}, // R2
        '{1'b1, 1'b0, 1'b0, 16'h00B2, 1'b1, 16'h00B2, 3'd2, 1'b0}, // R2
        '{1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 16'h00B2, 3'd2, 1'b0}, // R10
        '{1'b0, 1'b0, 1'b1, 16'h00C3, 1'b1, 16'h00C3, 3'd2, 1'b0}, // R4
        '{1'b0, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h00A1, 3'd1, 1'b0}, // R3
        '{1'b1, 1'b1, 1'b0, 16'h00D4, 1'b1, 16'h00D4, 3'd2, 1'b0}, // R5 push wins
        '{1'b0, 1'b1, 1'b1, 16'h00E5, 1'b1, 16'h00A1, 3'd1, 1'b0}, // R5 pop wins
        '{1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 1'b0}, // R3 R9
        '{1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 1'b1}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic o, input logic r, input logic [DW-1:0] d);
        push_i = p; pop_i = o; repl_i = r; wdata_i = d;
        @(posedge clk);
        #2;
        push_i = 0; pop_i = 0; repl_i = 0;
    endtask

    task automatic do_reset();
        rst = 1; push_i = 0; pop_i = 0; repl_i = 0; wdata_i = '0;
        @(posedge clk); @(posedge clk); #2;
        rst = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 depth", depth_o, 0);
        chk("R1 empty", empty_o, 1);
        chk("R1 full",  full_o, 0);
        chk("R1 err",   err_o, 0);
        chk("R1 valid", top_valid_o, 0);
        chk("R1 top",   top_o, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].push, VEC[i].pop, VEC[i].repl, VEC[i].data);
            chk($sformatf("vec%0d top", i),   top_o, VEC[i].top);
            chk($sformatf("vec%0d valid", i), top_valid_o, VEC[i].valid);
            chk($sformatf("vec%0d depth", i), depth_o, VEC[i].depth);
            chk($sformatf("vec%0d err", i),   err_o, VEC[i].err);
        end

        step(0, 0, 0, 16'h1234);
        chk("R8 err held", err_o, 1);
        do_reset();
        chk("R1 err cleared", err_o, 0);

        step(0, 0, 1, 16'h0055);
        chk("R7 repl empty err", err_o, 1);
        chk("R7 repl empty depth", depth_o, 0);
        chk("R9 empty top zero", top_o, 0);
        do_reset();

        for (int k = 0; k < DP; k++) begin
            step(1, 0, 0, DW'(16'h0010 + k));
            chk("R2 fill top", top_o, 16'h0010 + k);
        end
        chk("R9 full", full_o, 1);
        chk("R9 not empty", empty_o, 0);
        chk("R9 depth max", depth_o, DP);

        step(1, 0, 0, 16'h0099);
        chk("R6 overflow err", err_o, 1);
        chk("R6 overflow depth", depth_o, DP);
        chk("R6 overflow top", top_o, 16'h0013);

        step(0, 0, 1, 16'h0077);
        chk("R4 repl when full", top_o, 16'h0077);

        for (int k = DP - 2; k >= 0; k--) begin
            step(0, 1, 0, '0);
            chk("R3 lifo top", top_o, 16'h0010 + k);
            chk("R3 lifo depth", depth_o, k + 1);
        end
        step(0, 1, 0, '0);
        chk("R9 empty after drain", empty_o, 1);
        chk("R9 invalid after drain", top_valid_o, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule